// File: doc/BRIEF.md
# Delta-Cycle Phase Sequencer

This block is the scheduling core of a hardware emulation of event-driven simulation. Statement logic elsewhere reports four levels of pending work: active, inactive, nonblocking-update and monitor. The sequencer picks one class per pass on the emulation clock and fires a one-cycle start strobe for it. Every pass is split into an evaluation step, where the choice is made and the strobe issued, and an update step, where a separate strobe lets the downstream registers take the values just computed. Updates then make new processes pending, and evaluations make new updates pending.

When all four classes are quiet, the block reads its own table of timed entries. It moves simulated time straight to the time of the next entry and applies that entry's value to the output slot it names. The table is written through a load port while the block is idle. A start pulse then begins the run. A done flag shows when the table is used up and nothing is pending.

Top module: `dsq_sequencer`

## Requirements
- R1: After reset, and while idle before a start pulse, every strobe, `apply_en` and `done` are 0 and `sim_time` is 0. Pending flags have no effect until a start pulse.
- R2: When `pend_active` is high at an evaluation step, only `go_active` pulses one cycle later, whatever the other flags are.
- R3: When `pend_active` is low, the choice follows this priority: `go_inactive` before `go_nba` before `go_monitor`. Exactly one strobe fires for the highest pending class.
- R4: Each class strobe or timed apply is followed in the next cycle by one `go_update` pulse. Pending flags present in the cycle of the strobe are ignored.
- R5: Every strobe (`go_active`, `go_inactive`, `go_nba`, `go_monitor`, `go_update`, `apply_en`) lasts one cycle, and at most one of them is high in any cycle.
- R6: Time moves only when all four flags are low at an evaluation step and a table entry remains. Then `sim_time` takes the entry's time, and `apply_en` pulses with the entry's `apply_idx` and `apply_val`, in the same cycle. `sim_time` is an unsigned counter that resets to 0.
- R7: Entries are applied in table order (address 0 upward), one per pass, up to `entry_count`. An entry with the same time as the current time is applied without changing `sim_time`.
- R8: `sim_time` never decreases. An entry whose time is below the current time is applied at the current time.
- R9: `done` rises one cycle after an evaluation step that finds all flags low and the table used up. No update step follows it. `done` falls again when a later evaluation step issues a strobe.
- R10: Writes on the load port while a run is in progress are ignored. An entry not yet applied keeps the value it had at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one table entry (idle only) |
| load_addr | input | AW (3) | Table address of the entry |
| load_time | input | TIME_W (32) | Entry time stamp |
| load_idx | input | IW (3) | Entry target output slot |
| load_val | input | VAL_W (8) | Entry value |
| entry_count | input | CW (4) | Number of valid entries, latched at start |
| start | input | 1 | Begin a run from idle |
| pend_active | input | 1 | Active events pending |
| pend_inactive | input | 1 | Inactive events pending |
| pend_nba | input | 1 | Nonblocking-update events pending |
| pend_monitor | input | 1 | Monitor events pending |
| go_active | output | 1 | Activation strobe, active class |
| go_inactive | output | 1 | Activation strobe, inactive class |
| go_nba | output | 1 | Activation strobe, nonblocking-update class |
| go_monitor | output | 1 | Activation strobe, monitor class |
| go_update | output | 1 | Update-step strobe |
| apply_en | output | 1 | Timed entry applied this cycle |
| apply_idx | output | IW (3) | Output slot of the applied entry |
| apply_val | output | VAL_W (8) | Value of the applied entry |
| sim_time | output | TIME_W (32) | Current simulated time |
| done | output | 1 | Table used up and nothing pending |

## Verification
The hardest case to reach is a table entry whose time lies behind the current time. A sorted table never produces one, so the bench loads an entry at time 5 after an entry at time 7 and checks that `sim_time` stays at 7 while the value is still applied. Ignored inputs are also hard to reach, because they only exist in narrow windows. During each update step the bench drives the inverted flag pattern. During a run it rewrites an entry that has not yet been applied, then checks that the next evaluation and the later apply follow the original data. A bench-side queue model predicts every strobe, time jump and done transition.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  // choice made at an evaluation step
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_ACT   = 3'd1,
    SEL_INACT = 3'd2,
    SEL_NBA   = 3'd3,
    SEL_MON   = 3'd4,
    SEL_TIMED = 3'd5
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_EVAL = 2'd2,
    ST_UPD  = 2'd3
  } state_e;

  localparam int NCLS = 4;
endpackage

// File: rtl/dsq_arbiter.sv
module dsq_arbiter
  import dsq_pkg::*;
(
  input  logic [NCLS-1:0] pend,       // bit0 highest priority
  input  logic            have_entry,
  output sel_e            sel
);
  always_comb begin
    sel = have_entry ? SEL_TIMED : SEL_NONE;
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (pend[i]) sel = sel_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/dsq_table.sv
module dsq_table #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 32,
  parameter int IW     = 3,
  parameter int VAL_W  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = TIME_W + IW + VAL_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [TIME_W-1:0] wtime,
  input  logic [IW-1:0]     widx,
  input  logic [VAL_W-1:0]  wval,
  input  logic [AW-1:0]     raddr,
  output logic [TIME_W-1:0] rtime,
  output logic [IW-1:0]     ridx,
  output logic [VAL_W-1:0]  rval
);
  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;

  // single write port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wtime, widx, wval};
    rd_q <= mem[raddr];
  end

  assign {rtime, ridx, rval} = rd_q;
endmodule

// File: rtl/dsq_timekeep.sv
module dsq_timekeep #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [TIME_W-1:0] target,
  output logic [TIME_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
    end else if (advance && (target > now)) begin
      now <= target;
    end
  end
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_OUT = 8,
  parameter int VAL_W   = 8,
  parameter int TIME_W  = 32,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IW     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [AW-1:0]     load_addr,
  input  logic [TIME_W-1:0] load_time,
  input  logic [IW-1:0]     load_idx,
  input  logic [VAL_W-1:0]  load_val,
  input  logic [CW-1:0]     entry_count,
  input  logic              start,
  input  logic              pend_active,
  input  logic              pend_inactive,
  input  logic              pend_nba,
  input  logic              pend_monitor,
  output logic              go_active,
  output logic              go_inactive,
  output logic              go_nba,
  output logic              go_monitor,
  output logic              go_update,
  output logic              apply_en,
  output logic [IW-1:0]     apply_idx,
  output logic [VAL_W-1:0]  apply_val,
  output logic [TIME_W-1:0] sim_time,
  output logic              done
);
  state_e            state_q;
  logic [CW-1:0]     rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic [TIME_W-1:0] ent_time;
  logic [IW-1:0]     ent_idx;
  logic [VAL_W-1:0]  ent_val;
  logic              have_entry;
  logic              time_adv;
  sel_e              sel;

  assign have_entry = (rd_ptr_q < count_q);

  dsq_arbiter u_arb (
    .pend       ({pend_monitor, pend_nba, pend_inactive, pend_active}),
    .have_entry (have_entry),
    .sel        (sel)
  );

  dsq_table #(
    .DEPTH(DEPTH), .TIME_W(TIME_W), .IW(IW), .VAL_W(VAL_W)
  ) u_tab (
    .clk   (clk),
    .we    (load_en && (state_q == ST_IDLE)),
    .waddr (load_addr),
    .wtime (load_time),
    .widx  (load_idx),
    .wval  (load_val),
    .raddr (rd_ptr_q[AW-1:0]),
    .rtime (ent_time),
    .ridx  (ent_idx),
    .rval  (ent_val)
  );

  assign time_adv = (state_q == ST_EVAL) && (sel == SEL_TIMED);

  dsq_timekeep #(.TIME_W(TIME_W)) u_time (
    .clk     (clk),
    .rst     (rst),
    .advance (time_adv),
    .target  (ent_time),
    .now     (sim_time)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rd_ptr_q    <= '0;
      count_q     <= '0;
      go_active   <= 1'b0;
      go_inactive <= 1'b0;
      go_nba      <= 1'b0;
      go_monitor  <= 1'b0;
      go_update   <= 1'b0;
      apply_en    <= 1'b0;
      apply_idx   <= '0;
      apply_val   <= '0;
      done        <= 1'b0;
    end else begin
      go_active   <= 1'b0;
      go_inactive <= 1'b0;
      go_nba      <= 1'b0;
      go_monitor  <= 1'b0;
      go_update   <= 1'b0;
      apply_en    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            count_q  <= (entry_count > CW'(DEPTH)) ? CW'(DEPTH) : entry_count;
            rd_ptr_q <= '0;
            state_q  <= ST_SYNC;
          end
        end
        ST_SYNC: state_q <= ST_EVAL;   // lets the first table read settle
        ST_EVAL: begin
          if (sel == SEL_NONE) begin
            done <= 1'b1;
          end else begin
            done    <= 1'b0;
            state_q <= ST_UPD;
            unique case (sel)
              SEL_ACT:   go_active   <= 1'b1;
              SEL_INACT: go_inactive <= 1'b1;
              SEL_NBA:   go_nba      <= 1'b1;
              SEL_MON:   go_monitor  <= 1'b1;
              default: begin
                apply_en  <= 1'b1;
                apply_idx <= ent_idx;
                apply_val <= ent_val;
                rd_ptr_q  <= rd_ptr_q + CW'(1);
              end
            endcase
          end
        end
        ST_UPD: begin
          go_update <= 1'b1;
          state_q   <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsq_sequencer_chk.sv
module dsq_sequencer_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pend_active,
  input logic              pend_inactive,
  input logic              pend_nba,
  input logic              pend_monitor,
  input logic              go_active,
  input logic              go_inactive,
  input logic              go_nba,
  input logic              go_monitor,
  input logic              go_update,
  input logic              apply_en,
  input logic [TIME_W-1:0] sim_time,
  input logic              done
);
  logic any_issue;
  assign any_issue = go_active | go_inactive | go_nba | go_monitor | apply_en;

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_active, go_inactive, go_nba, go_monitor, go_update, apply_en}));

  assert_update_single_R5: assert property (@(posedge clk) disable iff (rst)
    go_update |=> !go_update);

  assert_update_follows_R4: assert property (@(posedge clk) disable iff (rst)
    any_issue |=> go_update);

  assert_active_first_R2: assert property (@(posedge clk) disable iff (rst)
    (go_inactive || go_nba || go_monitor || apply_en) |-> !$past(pend_active));

  assert_active_cause_R2: assert property (@(posedge clk) disable iff (rst)
    go_active |-> $past(pend_active));

  assert_nba_order_R3: assert property (@(posedge clk) disable iff (rst)
    go_nba |-> $past(!pend_inactive && pend_nba));

  assert_monitor_order_R3: assert property (@(posedge clk) disable iff (rst)
    go_monitor |-> $past(!pend_inactive && !pend_nba && pend_monitor));

  assert_apply_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    apply_en |-> $past(!pend_inactive && !pend_nba && !pend_monitor));

  assert_time_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !apply_en |-> $stable(sim_time));

  assert_time_mono_R8: assert property (@(posedge clk) disable iff (rst)
    apply_en |-> (sim_time >= $past(sim_time)));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !(any_issue || go_update));
endmodule

bind dsq_sequencer dsq_sequencer_chk #(.TIME_W(TIME_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .pend_active   (pend_active),
  .pend_inactive (pend_inactive),
  .pend_nba      (pend_nba),
  .pend_monitor  (pend_monitor),
  .go_active     (go_active),
  .go_inactive   (go_inactive),
  .go_nba        (go_nba),
  .go_monitor    (go_monitor),
  .go_update     (go_update),
  .apply_en      (apply_en),
  .sim_time      (sim_time),
  .done          (done)
);

// File: tb/dsq_sequencer_tb.sv
`timescale 1ns/1ps
module dsq_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [2:0]  load_addr = '0;
  logic [31:0] load_time = '0;
  logic [2:0]  load_idx = '0;
  logic [7:0]  load_val = '0;
  logic [3:0]  entry_count = '0;
  logic        start = 1'b0;
  logic        pend_active = 1'b0, pend_inactive = 1'b0, pend_nba = 1'b0, pend_monitor = 1'b0;
  logic        go_active, go_inactive, go_nba, go_monitor, go_update, apply_en, done;
  logic [2:0]  apply_idx;
  logic [7:0]  apply_val;
  logic [31:0] sim_time;

  int checks = 0;
  int errors = 0;

  // bench-side queue model
  logic [31:0] m_time [5];
  logic [2:0]  m_idx  [5];
  logic [7:0]  m_val  [5];
  int          m_ptr = 0;
  int          m_cnt = 0;
  logic [31:0] m_now = 0;

  always #2 clk = ~clk;

  dsq_sequencer u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_time(load_time), .load_idx(load_idx), .load_val(load_val),
    .entry_count(entry_count), .start(start),
    .pend_active(pend_active), .pend_inactive(pend_inactive),
    .pend_nba(pend_nba), .pend_monitor(pend_monitor),
    .go_active(go_active), .go_inactive(go_inactive), .go_nba(go_nba),
    .go_monitor(go_monitor), .go_update(go_update), .apply_en(apply_en),
    .apply_idx(apply_idx), .apply_val(apply_val), .sim_time(sim_time), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [3:0] f);
    {pend_monitor, pend_nba, pend_inactive, pend_active} = f;
  endtask

  function automatic logic [3:0] strobes();
    return {go_monitor, go_nba, go_inactive, go_active};
  endfunction

  // one evaluation step plus its update step, predicted by the model
  task automatic run_pass(input logic [3:0] f, input string req);
    logic [3:0] exp_go;
    logic       exp_apply;
    set_flags(f);
    exp_go = f & (~f + 4'd1);
    exp_apply = (f == 4'd0) && (m_ptr < m_cnt);
    @(negedge clk);
    chk({req, " strobe"}, 64'(strobes()), 64'(exp_go));
    chk({req, " apply_en"}, 64'(apply_en), 64'(exp_apply));
    if (exp_apply) begin
      if (m_time[m_ptr] > m_now) m_now = m_time[m_ptr];
      chk({req, " apply_idx"}, 64'(apply_idx), 64'(m_idx[m_ptr]));
      chk({req, " apply_val"}, 64'(apply_val), 64'(m_val[m_ptr]));
      m_ptr++;
    end
    chk({req, " sim_time"}, 64'(sim_time), 64'(m_now));
    if (exp_go != 4'd0 || exp_apply) begin
      chk({req, " done low"}, 64'(done), 64'd0);
      set_flags(~f);                          // must be ignored in update step (R4)
      @(negedge clk);
      chk("R4 update pulse", 64'(go_update), 64'd1);
      chk("R5 strobes cleared", 64'({strobes(), apply_en}), 64'd0);
      set_flags(4'd0);
    end else begin
      chk("R9 done set", 64'(done), 64'd1);
      @(negedge clk);
      chk("R9 no update when idle", 64'({go_update, strobes(), apply_en}), 64'd0);
      chk("R9 done held", 64'(done), 64'd1);
    end
  endtask

  task automatic put(input int a, input logic [31:0] t, input logic [2:0] i, input logic [7:0] v);
    load_en = 1'b1; load_addr = 3'(a); load_time = t; load_idx = i; load_val = v;
    m_time[a] = t; m_idx[a] = i; m_val[a] = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    set_flags(4'hF);                          // idle: flags have no effect
    repeat (3) @(negedge clk);
    chk("R1 strobes at idle", 64'({go_update, strobes(), apply_en}), 64'd0);
    chk("R1 sim_time zero", 64'(sim_time), 64'd0);
    chk("R1 done low", 64'(done), 64'd0);
    set_flags(4'd0);
  endtask

  task automatic t_start();
    put(0, 32'd2, 3'd0, 8'h11);
    put(1, 32'd3, 3'd1, 8'h22);
    put(2, 32'd3, 3'd2, 8'h33);
    put(3, 32'd7, 3'd1, 8'h44);
    put(4, 32'd5, 3'd3, 8'h55);
    m_cnt = 5; m_ptr = 0; m_now = 0;
    entry_count = 4'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_priority();
    for (int p = 1; p < 16; p++) begin
      if (p[0]) run_pass(4'(p), "R2 active wins");
      else      run_pass(4'(p), "R3 class priority");
    end
  endtask

  task automatic t_timed();
    run_pass(4'd0, "R6 jump to time 2");
    run_pass(4'b0001, "R2 active at time 2");
    load_en = 1'b1; load_addr = 3'd3; load_time = 32'd1; load_val = 8'h99;
    run_pass(4'd0, "R7 entry at time 3");
    load_en = 1'b0;
    run_pass(4'd0, "R7 same time entry");
    run_pass(4'd0, "R10 unchanged entry at time 7");
    run_pass(4'd0, "R8 late entry keeps time");
  endtask

  task automatic t_done();
    run_pass(4'd0, "R9 table exhausted");
    run_pass(4'b1000, "R9 monitor clears done");
    run_pass(4'b0100, "R3 nba after done");
    run_pass(4'd0, "R9 done again");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_priority();
    t_timed();
    t_done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule